// File: doc/BRIEF.md
# AXI4 Protocol Rule Monitor

This block sits passively beside a 32-bit AXI4 link and watches all five channels (write address, write data, write response, read address, read data). It never drives the bus. Every cycle it evaluates a fixed set of protocol rules. Whenever one is broken, a dedicated violation bit is latched. The bit stays set until the next reset.

The rules encode a narrowed AXI4 profile with these parts:
- No VALID may be high while reset is held.
- VALID, once raised, must remain high until its READY has been seen.
- The write address fields and the write data fields must hold still while a transfer is waiting.
- Only FIXED and INCR burst codes are accepted.
- Transfer sizes are limited to the bus width.
- Responses are limited to OKAY and SLVERR.

Field legality is judged only in cycles where the matching VALID is high.

A single aggregate error output is the OR of all violation bits. It lets a chip raise one interrupt or a debug trigger. The individual bits identify the rule that tripped.

Top module: `axi_rule_monitor`

## Requirements
- R1: After reset with an idle bus, all 14 bits of `viol_flags` and `any_error` read 0.
- R2: Bit 0 of `viol_flags` is set if any of the five VALID inputs is high in a cycle with `rst` high. This bit survives the release of reset. It is cleared only at the first cycle of a later reset in which no VALID is high.
- R3: Bits 1 to 5 (write address, write data, write response, read address, read data) are set when the channel's VALID was high with READY low at one clock edge and is low at the next edge.
- R4: VALID falling after a cycle in which READY was high sets no flag.
- R5: Bit 6 is set when `aw_addr`, `aw_id` or `aw_len` changes between two edges while `aw_valid` stays high and `aw_ready` was low at the first of them.
- R6: Bit 7 is set when `w_data`, `w_strb` or `w_last` changes under the same condition on the write data channel. Changes after a completed handshake set nothing.
- R7: Bit 8 covers `b_resp` and bit 9 covers `r_resp`. Code 00 (OKAY) and code 10 (SLVERR) are legal. Codes 01 and 11 set the bit only when the channel's VALID is high.
- R8: Bit 10 covers `aw_burst` and bit 11 covers `ar_burst`. Codes 00 (FIXED) and 01 (INCR) are legal. Codes 10 and 11 with VALID high set the bit.
- R9: Bit 12 covers `aw_size` and bit 13 covers `ar_size`. A size above 2 with VALID high sets the bit.
- R10: Flags are sticky until reset, and several flags can be set together. A violation sampled at one clock edge shows on `viol_flags` and `any_error` right after that edge. `any_error` is the OR of all bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | input | ADDR_W | Write address |
| aw_id | input | ID_W | Write transaction ID |
| aw_len | input | LEN_W | Write burst length |
| aw_size | input | 3 | Write beat size code |
| aw_burst | input | 2 | Write burst type code |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_data | input | DATA_W | Write data |
| w_strb | input | DATA_W/8 | Write byte strobes |
| w_last | input | 1 | Last write beat |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_resp | input | 2 | Write response code |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_size | input | 3 | Read beat size code |
| ar_burst | input | 2 | Read burst type code |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_resp | input | 2 | Read response code |
| viol_flags | output | 14 | Sticky per-rule violation bits |
| any_error | output | 1 | OR of all violation bits |

## Verification
The hardest case to reach from the ports is the reset rule. Its flag must be set while reset is active, yet reset also clears every other flag. The stimulus raises a read-address VALID inside a reset window, then releases reset and reads the bit. A second, clean reset must then clear it.

The payload-stability rules need a stall: the bench holds VALID with READY low across two edges and changes one field between them. It also shows that the same change right after a completed handshake leaves the flag clear.

// File: rtl/axi_rule_pkg.sv
package axi_rule_pkg;
  localparam int NUM_RULES   = 14;
  localparam int RULE_RST    = 0;
  localparam int RULE_AW_DRP = 1;
  localparam int RULE_W_DRP  = 2;
  localparam int RULE_B_DRP  = 3;
  localparam int RULE_AR_DRP = 4;
  localparam int RULE_R_DRP  = 5;
  localparam int RULE_AW_CHG = 6;
  localparam int RULE_W_CHG  = 7;
  localparam int RULE_B_CODE = 8;
  localparam int RULE_R_CODE = 9;
  localparam int RULE_AW_BT  = 10;
  localparam int RULE_AR_BT  = 11;
  localparam int RULE_AW_SZ  = 12;
  localparam int RULE_AR_SZ  = 13;
  localparam int NUM_CHAN    = 5;
endpackage

// File: rtl/chan_hold_check.sv
module chan_hold_check #(
  parameter int PAYLOAD_W     = 8,
  parameter bit CHECK_PAYLOAD = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid,
  input  logic                 ready,
  input  logic [PAYLOAD_W-1:0] payload,
  output logic                 drop_err,
  output logic                 change_err
);
  logic                 waiting_q;
  logic [PAYLOAD_W-1:0] payload_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting_q <= 1'b0;
      payload_q <= '0;
    end else begin
      waiting_q <= valid && !ready;
      payload_q <= payload;
    end
  end

  assign drop_err   = waiting_q && !valid;
  assign change_err = CHECK_PAYLOAD && waiting_q && valid && (payload != payload_q);
endmodule

// File: rtl/code_legal.sv
module code_legal #(
  parameter int                  CODE_W     = 2,
  parameter logic [(1<<CODE_W)-1:0] LEGAL_MASK = '1
) (
  input  logic              valid,
  input  logic [CODE_W-1:0] code,
  output logic              bad
);
  assign bad = valid && !LEGAL_MASK[code];
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int N = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rst_hit,
  input  logic [N-1:0] set_vec,
  output logic [N-1:0] flags,
  output logic         any_err
);
  logic         in_rst_q = 1'b0;
  logic [N-1:0] flags_nxt;

  always_comb begin
    if (rst) begin
      flags_nxt    = '0;
      flags_nxt[0] = (in_rst_q && flags[0]) || rst_hit;
    end else begin
      flags_nxt = flags | set_vec;
    end
  end

  always_ff @(posedge clk) begin
    in_rst_q <= rst;
    flags    <= flags_nxt;
    any_err  <= |flags_nxt;
  end
endmodule

// File: rtl/axi_rule_monitor.sv
module axi_rule_monitor
  import axi_rule_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  aw_valid,
  input  logic                  aw_ready,
  input  logic [ADDR_W-1:0]     aw_addr,
  input  logic [ID_W-1:0]       aw_id,
  input  logic [LEN_W-1:0]      aw_len,
  input  logic [2:0]            aw_size,
  input  logic [1:0]            aw_burst,
  input  logic                  w_valid,
  input  logic                  w_ready,
  input  logic [DATA_W-1:0]     w_data,
  input  logic [DATA_W/8-1:0]   w_strb,
  input  logic                  w_last,
  input  logic                  b_valid,
  input  logic                  b_ready,
  input  logic [1:0]            b_resp,
  input  logic                  ar_valid,
  input  logic                  ar_ready,
  input  logic [2:0]            ar_size,
  input  logic [1:0]            ar_burst,
  input  logic                  r_valid,
  input  logic                  r_ready,
  input  logic [1:0]            r_resp,
  output logic [NUM_RULES-1:0]  viol_flags,
  output logic                  any_error
);
  localparam int STRB_W   = DATA_W / 8;
  localparam int MAX_SIZE = $clog2(STRB_W);
  localparam int AW_PW    = ADDR_W + ID_W + LEN_W;
  localparam int W_PW     = DATA_W + STRB_W + 1;
  localparam logic [7:0] SIZE_OK  = (8'd1 << (MAX_SIZE + 1)) - 8'd1;
  localparam logic [3:0] RESP_OK  = 4'b0101;
  localparam logic [3:0] BURST_OK = 4'b0011;

  logic [NUM_CHAN-1:0] ch_valid, ch_ready, ch_drop, ch_chg;
  logic [NUM_RULES-1:0] set_vec;

  assign ch_valid = {r_valid, ar_valid, b_valid, w_valid, aw_valid};
  assign ch_ready = {r_ready, ar_ready, b_ready, w_ready, aw_ready};

  chan_hold_check #(.PAYLOAD_W(AW_PW), .CHECK_PAYLOAD(1'b1)) u_aw (
    .clk(clk), .rst(rst), .valid(ch_valid[0]), .ready(ch_ready[0]),
    .payload({aw_addr, aw_id, aw_len}), .drop_err(ch_drop[0]), .change_err(ch_chg[0]));

  chan_hold_check #(.PAYLOAD_W(W_PW), .CHECK_PAYLOAD(1'b1)) u_w (
    .clk(clk), .rst(rst), .valid(ch_valid[1]), .ready(ch_ready[1]),
    .payload({w_data, w_strb, w_last}), .drop_err(ch_drop[1]), .change_err(ch_chg[1]));

  genvar gi;
  generate
    for (gi = 2; gi < NUM_CHAN; gi++) begin : g_plain
      chan_hold_check #(.PAYLOAD_W(1), .CHECK_PAYLOAD(1'b0)) u_ch (
        .clk(clk), .rst(rst), .valid(ch_valid[gi]), .ready(ch_ready[gi]),
        .payload(1'b0), .drop_err(ch_drop[gi]), .change_err(ch_chg[gi]));
    end
  endgenerate

  logic b_code_bad, r_code_bad, aw_bt_bad, ar_bt_bad, aw_sz_bad, ar_sz_bad;

  code_legal #(.CODE_W(2), .LEGAL_MASK(RESP_OK)) u_b_code (
    .valid(b_valid), .code(b_resp), .bad(b_code_bad));
  code_legal #(.CODE_W(2), .LEGAL_MASK(RESP_OK)) u_r_code (
    .valid(r_valid), .code(r_resp), .bad(r_code_bad));
  code_legal #(.CODE_W(2), .LEGAL_MASK(BURST_OK)) u_aw_bt (
    .valid(aw_valid), .code(aw_burst), .bad(aw_bt_bad));
  code_legal #(.CODE_W(2), .LEGAL_MASK(BURST_OK)) u_ar_bt (
    .valid(ar_valid), .code(ar_burst), .bad(ar_bt_bad));
  code_legal #(.CODE_W(3), .LEGAL_MASK(SIZE_OK)) u_aw_sz (
    .valid(aw_valid), .code(aw_size), .bad(aw_sz_bad));
  code_legal #(.CODE_W(3), .LEGAL_MASK(SIZE_OK)) u_ar_sz (
    .valid(ar_valid), .code(ar_size), .bad(ar_sz_bad));

  always_comb begin
    set_vec              = '0;
    set_vec[RULE_AW_DRP] = ch_drop[0];
    set_vec[RULE_W_DRP]  = ch_drop[1];
    set_vec[RULE_B_DRP]  = ch_drop[2];
    set_vec[RULE_AR_DRP] = ch_drop[3];
    set_vec[RULE_R_DRP]  = ch_drop[4];
    set_vec[RULE_AW_CHG] = ch_chg[0];
    set_vec[RULE_W_CHG]  = ch_chg[1];
    set_vec[RULE_B_CODE] = b_code_bad;
    set_vec[RULE_R_CODE] = r_code_bad;
    set_vec[RULE_AW_BT]  = aw_bt_bad;
    set_vec[RULE_AR_BT]  = ar_bt_bad;
    set_vec[RULE_AW_SZ]  = aw_sz_bad;
    set_vec[RULE_AR_SZ]  = ar_sz_bad;
  end

  flag_bank #(.N(NUM_RULES)) u_flags (
    .clk(clk), .rst(rst), .rst_hit(|ch_valid), .set_vec(set_vec),
    .flags(viol_flags), .any_err(any_error));
endmodule

// File: rtl/axi_rule_monitor_sva.sv
module axi_rule_monitor_sva (
  input logic        clk,
  input logic        rst,
  input logic        aw_valid,
  input logic        aw_ready,
  input logic [2:0]  aw_size,
  input logic        b_valid,
  input logic [1:0]  b_resp,
  input logic        ar_valid,
  input logic [13:0] viol_flags,
  input logic        any_error
);
  // R2
  assert_rst_valid_R2: assert property (@(posedge clk)
    rst && ar_valid |=> viol_flags[0]);

  // R3
  assert_aw_drop_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(aw_valid) && !$past(aw_ready) && !aw_valid |=> viol_flags[1]);

  // R7
  assert_b_code_R7: assert property (@(posedge clk) disable iff (rst)
    b_valid && b_resp[0] |=> viol_flags[8]);

  // R9
  assert_aw_size_R9: assert property (@(posedge clk) disable iff (rst)
    aw_valid && (aw_size > 3'd2) |=> viol_flags[12]);

  // R10
  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((viol_flags & $past(viol_flags)) == $past(viol_flags)));

  assert_error_or_R10: assert property (@(posedge clk) disable iff (rst)
    any_error == (|viol_flags));
endmodule

bind axi_rule_monitor axi_rule_monitor_sva u_sva (
  .clk(clk), .rst(rst), .aw_valid(aw_valid), .aw_ready(aw_ready),
  .aw_size(aw_size), .b_valid(b_valid), .b_resp(b_resp),
  .ar_valid(ar_valid), .viol_flags(viol_flags), .any_error(any_error));

// File: tb/axi_rule_monitor_test.sv
module axi_rule_monitor_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        aw_valid, aw_ready, w_valid, w_ready, w_last;
  logic        b_valid, b_ready, ar_valid, ar_ready, r_valid, r_ready;
  logic [31:0] aw_addr, w_data;
  logic [3:0]  aw_id, w_strb;
  logic [7:0]  aw_len;
  logic [2:0]  aw_size, ar_size;
  logic [1:0]  aw_burst, ar_burst, b_resp, r_resp;
  logic [13:0] viol_flags;
  logic        any_error;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  axi_rule_monitor uut (
    .clk(clk), .rst(rst),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_id(aw_id),
    .aw_len(aw_len), .aw_size(aw_size), .aw_burst(aw_burst),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_size(ar_size), .ar_burst(ar_burst),
    .r_valid(r_valid), .r_ready(r_ready), .r_resp(r_resp),
    .viol_flags(viol_flags), .any_error(any_error));

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic check(string req, logic [13:0] exp_flags);
    compared++;
    if (viol_flags !== exp_flags || any_error !== (|exp_flags)) begin
      mismatched++;
      $display("FAIL %s: flags=%b err=%b expected flags=%b err=%b",
               req, viol_flags, any_error, exp_flags, |exp_flags);
    end
  endtask

  task automatic idle();
    aw_valid = 0; aw_ready = 0; aw_addr = 32'h100; aw_id = 4'h3; aw_len = 8'd3;
    aw_size = 3'd2; aw_burst = 2'b01;
    w_valid = 0; w_ready = 0; w_data = 32'hA5A5_0001; w_strb = 4'hF; w_last = 0;
    b_valid = 0; b_ready = 0; b_resp = 2'b00;
    ar_valid = 0; ar_ready = 0; ar_size = 3'd2; ar_burst = 2'b00;
    r_valid = 0; r_ready = 0; r_resp = 2'b00;
  endtask

  task automatic do_reset();
    idle();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(1);
  endtask

  task automatic set_ch(int ch, logic v, logic r);
    case (ch)
      0: begin aw_valid = v; aw_ready = r; end
      1: begin w_valid = v; w_ready = r; end
      2: begin b_valid = v; b_ready = r; end
      3: begin ar_valid = v; ar_ready = r; end
      default: begin r_valid = v; r_ready = r; end
    endcase
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 idle after reset", 14'h0);
  endtask

  task automatic t_reset_valid();
    idle();
    rst = 1'b1;
    step(2);
    ar_valid = 1'b1;
    step(1);
    ar_valid = 1'b0;
    step(1);
    rst = 1'b0;
    step(2);
    check("R2 valid during reset", 14'h0001);
    do_reset();
    check("R2 cleared by clean reset", 14'h0);
  endtask

  task automatic t_drop();
    for (int ch = 0; ch < 5; ch++) begin
      do_reset();
      set_ch(ch, 1'b1, 1'b0);
      step(2);
      set_ch(ch, 1'b0, 1'b0);
      step(1);
      check("R3 valid dropped before ready", 14'(1 << (ch + 1)));
    end
  endtask

  task automatic t_drop_ok();
    do_reset();
    for (int ch = 0; ch < 5; ch++) begin
      set_ch(ch, 1'b1, 1'b0);
      step(1);
      set_ch(ch, 1'b1, 1'b1);
      step(1);
      set_ch(ch, 1'b0, 1'b0);
      step(1);
    end
    check("R4 drop after handshake", 14'h0);
  endtask

  task automatic t_aw_stable();
    do_reset();
    aw_valid = 1'b1;
    step(1);
    aw_addr = 32'h104;
    step(1);
    check("R5 aw_addr change while stalled", 14'h0040);
    do_reset();
    aw_valid = 1'b1;
    step(1);
    aw_len = 8'd7;
    step(1);
    check("R5 aw_len change while stalled", 14'h0040);
  endtask

  task automatic t_w_stable();
    do_reset();
    w_valid = 1'b1; w_ready = 1'b1;
    step(1);
    w_data = 32'h1234_5678; w_ready = 1'b0;
    step(1);
    check("R6 change after handshake", 14'h0);
    w_strb = 4'h3;
    step(1);
    check("R6 w_strb change while stalled", 14'h0080);
  endtask

  task automatic t_resp();
    do_reset();
    b_valid = 1'b1; b_ready = 1'b1; b_resp = 2'b10;
    r_valid = 1'b1; r_ready = 1'b1; r_resp = 2'b00;
    step(1);
    check("R7 legal OKAY/SLVERR", 14'h0);
    b_valid = 1'b0; r_valid = 1'b0; r_resp = 2'b11; b_resp = 2'b01;
    step(2);
    check("R7 illegal code without valid", 14'h0);
    b_valid = 1'b1;
    step(1);
    b_valid = 1'b0; b_resp = 2'b00;
    check("R7 b_resp 01", 14'h0100);
    r_valid = 1'b1;
    step(1);
    r_valid = 1'b0;
    check("R7 r_resp 11", 14'h0300);
  endtask

  task automatic t_burst_size();
    do_reset();
    aw_valid = 1'b1; aw_ready = 1'b1; aw_burst = 2'b00;
    ar_valid = 1'b1; ar_ready = 1'b1; ar_burst = 2'b01;
    step(1);
    check("R8 FIXED and INCR legal", 14'h0);
    ar_burst = 2'b10;
    step(1);
    ar_burst = 2'b01;
    check("R8 ar_burst 10", 14'h0800);
    aw_burst = 2'b11;
    step(1);
    aw_burst = 2'b01;
    check("R8 aw_burst 11", 14'h0C00);
    do_reset();
    aw_valid = 1'b1; aw_ready = 1'b1; ar_valid = 1'b1; ar_ready = 1'b1;
    aw_size = 3'd2; ar_size = 3'd0;
    step(1);
    check("R9 size 2 and 0 legal", 14'h0);
    aw_size = 3'd3;
    step(1);
    aw_size = 3'd2;
    check("R9 aw_size 3", 14'h1000);
    ar_size = 3'd7;
    step(1);
    ar_size = 3'd2;
    check("R9 ar_size 7", 14'h3000);
  endtask

  task automatic t_sticky();
    do_reset();
    r_valid = 1'b1; r_ready = 1'b1; r_resp = 2'b01;
    step(1);
    check("R10 flag right after offending edge", 14'h0200);
    r_resp = 2'b00;
    step(5);
    r_valid = 1'b0;
    step(3);
    check("R10 flag held after cause removed", 14'h0200);
    ar_valid = 1'b1; ar_ready = 1'b0;
    step(1);
    ar_valid = 1'b0;
    step(1);
    check("R10 second flag accumulates", 14'h0210);
    do_reset();
    check("R10 reset clears flags", 14'h0);
  endtask

  initial begin
    idle();
    step(1);
    t_reset_state();
    t_reset_valid();
    t_drop();
    t_drop_ok();
    t_aw_stable();
    t_w_stable();
    t_resp();
    t_burst_size();
    t_sticky();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule